// File: doc/BRIEF.md
# Staged Configuration Register Bank

This block holds the working configuration of a larger function as a bank of byte-wide registers, each built from two storage stages. The first stage collects new values; the second stage drives the configuration that the rest of the chip uses. A host changes values through a simple write port. An update-control register decides whether host writes reach the second stage at once or wait for a global commit.

When power becomes good, a loader reads one stored copy per register from a nonvolatile store through a request/valid read port. The store address of each register is its register address with a fixed high byte in front. The loader fills every first stage and then commits the whole bank on a single clock edge. The host can start the same bulk reload later to throw away its edits and go back to the stored values. While either kind of load runs, a busy flag is high so that the bus interface can refuse the access. Host writes made during that time are dropped. A fixed number of cycles after the power-up load completes, the block emits a start pulse for the downstream sequencer.

Top module: `cfg_bank`

## Requirements
- R1: After reset with power good, the active configuration keeps its reset value (all zero) while the load is running. Then every register takes its stored value on one and the same clock edge, and busy falls on that edge.
- R2: The load reads register i from store address {STORE_HI, i}, with STORE_HI = 0xF8 by default. It covers NUM_PAGES*PAGE_BYTES registers with exactly one read each. Each request is a single-cycle pulse, and the data is taken in the cycle that rd_valid is high.
- R3: With bit 0 of the update-control register (address CTRL_ADDR) set to 1, a host write to a register address below the bank size shows on cfg_q right after the write edge.
- R4: With bit 0 of the update-control register at 0, a host write to a register changes only its first stage, and cfg_q stays unchanged.
- R5: A host write to CTRL_ADDR with bit 1 set copies every first stage to the active configuration on that write's edge.
- R6: A host write to DNLD_ADDR with bit 0 set, made while idle, raises busy on the next edge. It reloads every register from the store and commits them all together, discarding staged host edits. The same write with bit 0 clear has no effect.
- R7: busy is high out of reset, and whenever power good was low in the previous cycle, until the power-up load has committed. Host writes while busy are dropped.
- R8: During a host-started reload, busy stays high. Host writes to registers and to the update-control register have no effect.
- R9: ctrl_o reads back {bit 1 = 0, bit 0 = transparent mode}. The commit bit always reads as 0.
- R10: seq_start is a one-cycle pulse exactly SEQ_DELAY cycles after the edge on which the power-up load commits. A host-started reload produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Supply good; low clears the loaded state |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write address (register, CTRL_ADDR or DNLD_ADDR) |
| wr_data | input | DATA_W | Host write data |
| rd_req | output | 1 | Store read request, one cycle |
| rd_addr | output | ADDR_W+8 | Store read address |
| rd_valid | input | 1 | Store read data valid |
| rd_data | input | DATA_W | Store read data |
| cfg_q | output | NUM_REGS*DATA_W | Active configuration, register i at bits i*DATA_W upward |
| ctrl_o | output | 2 | Update-control readback |
| busy | output | 1 | Load in progress or not yet loaded; host access refused |
| seq_start | output | 1 | Sequencer start pulse |

## Verification
The bench builds the bank with two pages of four bytes and SEQ_DELAY set to 25. A full load therefore takes only a few dozen cycles, and the test can watch every register's fill, the single commit edge and the delayed start pulse. A store model with a latency of two cycles returns an address-derived byte, so a wrong address or a lost register shows up as a wrong byte in cfg_q. These small sizes also let the test fit a host-started reload, with its dropped writes, and a power loss into one short run.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

   typedef enum logic [1:0] {
      LD_IDLE,
      LD_REQ,
      LD_WAIT,
      LD_COMMIT
   } ld_state_e;

   function automatic int idx_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/cfg_loader.sv
module cfg_loader
   import cfg_bank_pkg::*;
#(
   parameter int          NUM_REGS = 224,
   parameter int          DATA_W   = 8,
   parameter int          ADDR_W   = 8,
   parameter logic [7:0]  STORE_HI = 8'hF8,
   localparam int         IDX_W    = idx_width(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pwr_good,
   input  logic                user_go,
   output logic                rd_req,
   output logic [ADDR_W+7:0]   rd_addr,
   input  logic                rd_valid,
   input  logic [DATA_W-1:0]   rd_data,
   output logic                ld_we,
   output logic [IDX_W-1:0]    ld_idx,
   output logic [DATA_W-1:0]   ld_data,
   output logic                ld_commit,
   output logic                ld_pwrup,
   output logic                busy
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

   ld_state_e         state;
   logic [IDX_W-1:0]  idx;
   logic              loaded;
   logic              pwrup;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= LD_IDLE;
         idx    <= '0;
         loaded <= 1'b0;
         pwrup  <= 1'b0;
      end else if (!pwr_good) begin
         state  <= LD_IDLE;
         idx    <= '0;
         loaded <= 1'b0;
         pwrup  <= 1'b0;
      end else begin
         case (state)
            LD_IDLE: begin
               if (!loaded) begin
                  state <= LD_REQ;
                  idx   <= '0;
                  pwrup <= 1'b1;
               end else if (user_go) begin
                  state <= LD_REQ;
                  idx   <= '0;
                  pwrup <= 1'b0;
               end
            end
            LD_REQ:  state <= LD_WAIT;
            LD_WAIT: begin
               if (rd_valid) begin
                  if (idx == LAST_IDX) begin
                     state <= LD_COMMIT;
                  end else begin
                     idx   <= idx + 1'b1;
                     state <= LD_REQ;
                  end
               end
            end
            LD_COMMIT: begin
               state  <= LD_IDLE;
               loaded <= 1'b1;
            end
            default: state <= LD_IDLE;
         endcase
      end
   end

   assign rd_req    = (state == LD_REQ);
   assign rd_addr   = {STORE_HI, ADDR_W'(idx)};
   assign ld_we     = (state == LD_WAIT) && rd_valid;
   assign ld_idx    = idx;
   assign ld_data   = rd_data;
   assign ld_commit = (state == LD_COMMIT);
   assign ld_pwrup  = pwrup;
   assign busy      = !loaded || (state != LD_IDLE);

endmodule

// File: rtl/cfg_stage_cell.sv
module cfg_stage_cell #(
   parameter int                 DATA_W  = 8,
   parameter logic [DATA_W-1:0]  RST_VAL = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               a_we,
   input  logic [DATA_W-1:0]  a_d,
   input  logic               b_we,
   input  logic [DATA_W-1:0]  b_d,
   input  logic               commit,
   output logic [DATA_W-1:0]  q
);

   logic [DATA_W-1:0] stage_a;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_a <= RST_VAL;
         q       <= RST_VAL;
      end else begin
         if (a_we)   stage_a <= a_d;
         if (commit) q       <= stage_a;
         if (b_we)   q       <= b_d;
      end
   end

endmodule

// File: rtl/cfg_seq_timer.sv
module cfg_seq_timer #(
   parameter int  SEQ_DELAY = 25000,
   localparam int CNT_W     = $clog2(SEQ_DELAY + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   input  logic arm,
   output logic go
);

   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SEQ_DELAY - 1);

   logic             run;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         cnt <= '0;
         go  <= 1'b0;
      end else begin
         go <= 1'b0;
         if (!pwr_good) begin
            run <= 1'b0;
            cnt <= '0;
         end else if (arm) begin
            run <= 1'b1;
            cnt <= '0;
         end else if (run) begin
            if (cnt == LAST_CNT) begin
               go  <= 1'b1;
               run <= 1'b0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
   import cfg_bank_pkg::*;
#(
   parameter int                 DATA_W     = 8,
   parameter int                 ADDR_W     = 8,
   parameter int                 NUM_PAGES  = 7,
   parameter int                 PAGE_BYTES = 32,
   parameter logic [7:0]         STORE_HI   = 8'hF8,
   parameter logic [ADDR_W-1:0]  CTRL_ADDR  = 'hF0,
   parameter logic [ADDR_W-1:0]  DNLD_ADDR  = 'hF1,
   parameter int                 SEQ_DELAY  = 25000,
   localparam int                NUM_REGS   = NUM_PAGES * PAGE_BYTES,
   localparam int                CFG_W      = NUM_REGS * DATA_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pwr_good,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   output logic                rd_req,
   output logic [ADDR_W+7:0]   rd_addr,
   input  logic                rd_valid,
   input  logic [DATA_W-1:0]   rd_data,
   output logic [CFG_W-1:0]    cfg_q,
   output logic [1:0]          ctrl_o,
   output logic                busy,
   output logic                seq_start
);

   localparam int              IDX_W  = idx_width(NUM_REGS);
   localparam logic [ADDR_W:0] NREG_L = (ADDR_W + 1)'(NUM_REGS);

   if (NUM_REGS > (1 << ADDR_W)) begin : g_chk_span
      $error("cfg_bank: bank does not fit the address width");
   end
   if (CTRL_ADDR < NUM_REGS || DNLD_ADDR < NUM_REGS) begin : g_chk_ctl
      $error("cfg_bank: control addresses overlap the bank");
   end
   if (CTRL_ADDR == DNLD_ADDR) begin : g_chk_dup
      $error("cfg_bank: control addresses collide");
   end
   if (DATA_W < 2 || SEQ_DELAY < 1) begin : g_chk_misc
      $error("cfg_bank: DATA_W or SEQ_DELAY out of range");
   end

   logic               wr_ok, host_reg_we, ctrl_we, host_commit, user_go;
   logic               ctrl_transp;
   logic               ld_we, ld_commit, ld_pwrup, commit_all;
   logic [IDX_W-1:0]   ld_idx;
   logic [DATA_W-1:0]  ld_data;

   assign wr_ok       = wr_en && !busy;
   assign host_reg_we = wr_ok && ({1'b0, wr_addr} < NREG_L);
   assign ctrl_we     = wr_ok && (wr_addr == CTRL_ADDR);
   assign host_commit = ctrl_we && wr_data[1];
   assign user_go     = wr_ok && (wr_addr == DNLD_ADDR) && wr_data[0];
   assign commit_all  = ld_commit || host_commit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_transp <= 1'b0;
      else if (ctrl_we) ctrl_transp <= wr_data[0];
   end

   assign ctrl_o = {1'b0, ctrl_transp};

   cfg_loader #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .STORE_HI (STORE_HI)
   ) i_loader (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_good  (pwr_good),
      .user_go   (user_go),
      .rd_req    (rd_req),
      .rd_addr   (rd_addr),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .ld_we     (ld_we),
      .ld_idx    (ld_idx),
      .ld_data   (ld_data),
      .ld_commit (ld_commit),
      .ld_pwrup  (ld_pwrup),
      .busy      (busy)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic              sel_ld, sel_host;
      logic [DATA_W-1:0] a_d;

      assign sel_ld   = ld_we && (ld_idx == IDX_W'(i));
      assign sel_host = host_reg_we && (wr_addr == ADDR_W'(i));
      assign a_d      = sel_ld ? ld_data : wr_data;

      cfg_stage_cell #(
         .DATA_W (DATA_W)
      ) i_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .a_we   (sel_ld || sel_host),
         .a_d    (a_d),
         .b_we   (sel_host && ctrl_transp),
         .b_d    (wr_data),
         .commit (commit_all),
         .q      (cfg_q[i*DATA_W +: DATA_W])
      );
   end

   cfg_seq_timer #(
      .SEQ_DELAY (SEQ_DELAY)
   ) i_seq_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_good (pwr_good),
      .arm      (ld_commit && ld_pwrup),
      .go       (seq_start)
   );

endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk #(
   parameter int          NUM_REGS = 224,
   parameter int          DATA_W   = 8,
   parameter int          ADDR_W   = 8,
   parameter logic [7:0]  STORE_HI = 8'hF8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        pwr_good,
   input logic                        wr_en,
   input logic [ADDR_W-1:0]           wr_addr,
   input logic [DATA_W-1:0]           wr_data,
   input logic                        rd_req,
   input logic [ADDR_W+7:0]           rd_addr,
   input logic                        busy,
   input logic                        seq_start,
   input logic                        ctrl_transp,
   input logic [NUM_REGS*DATA_W-1:0]  cfg_q
);

   localparam logic [ADDR_W:0] NREG_L = (ADDR_W + 1)'(NUM_REGS);

   logic in_bank;
   assign in_bank = ({1'b0, wr_addr} < NREG_L);

   a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   a_r2_req_prefix: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (rd_addr[ADDR_W+7:ADDR_W] == STORE_HI));

   a_r7_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> busy);

   a_r7_busy_after_loss: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> busy);

   a_r4_staged_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr_en && !ctrl_transp && in_bank) |=> $stable(cfg_q));

   a_r3_transparent_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr_en && ctrl_transp && in_bank) |=>
      (cfg_q[int'($past(wr_addr))*DATA_W +: DATA_W] == $past(wr_data)));

   a_r10_seq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      seq_start |=> !seq_start);

endmodule

bind cfg_bank cfg_bank_chk #(
   .NUM_REGS (NUM_REGS),
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .STORE_HI (STORE_HI)
) i_cfg_bank_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pwr_good    (pwr_good),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .rd_req      (rd_req),
   .rd_addr     (rd_addr),
   .busy        (busy),
   .seq_start   (seq_start),
   .ctrl_transp (ctrl_transp),
   .cfg_q       (cfg_q)
);

// File: tb/test_cfg_bank.sv
module test_cfg_bank;

   localparam int         CLK_P  = 10;
   localparam int         NP     = 2;
   localparam int         PB     = 4;
   localparam int         NR     = NP * PB;
   localparam int         DW     = 8;
   localparam int         AW     = 8;
   localparam int         SD     = 25;
   localparam int         LAT    = 2;
   localparam int         CW     = NR * DW;
   localparam logic [7:0] A_CTRL = 8'hF0;
   localparam logic [7:0] A_DNLD = 8'hF1;

   localparam int K_CFG  = 0;
   localparam int K_BUSY = 1;
   localparam int K_CTRL = 2;

   logic          clk, rst_n, pwr_good, wr_en, rd_valid;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data, rd_data;
   logic          rd_req, busy, seq_start;
   logic [AW+7:0] rd_addr;
   logic [CW-1:0] cfg_q;
   logic [1:0]    ctrl_o;

   cfg_bank #(
      .DATA_W (DW), .ADDR_W (AW), .NUM_PAGES (NP), .PAGE_BYTES (PB),
      .STORE_HI (8'hF8), .CTRL_ADDR (A_CTRL), .DNLD_ADDR (A_DNLD),
      .SEQ_DELAY (SD)
   ) i_cfg_bank (
      .clk (clk), .rst_n (rst_n), .pwr_good (pwr_good),
      .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
      .rd_req (rd_req), .rd_addr (rd_addr), .rd_valid (rd_valid), .rd_data (rd_data),
      .cfg_q (cfg_q), .ctrl_o (ctrl_o), .busy (busy), .seq_start (seq_start)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int n_reads = 0;
   int n_badpre = 0;
   int n_seq = 0;
   int cyc = 0;
   int t_fall = -1;
   int t_seq = -1;

   typedef struct {
      int            kind;
      string         tag;
      logic [CW-1:0] exp;
   } item_t;
   item_t sbq[$];

   function automatic logic [DW-1:0] store_val(input logic [7:0] a);
      return 8'h30 + a * 8'd7;
   endfunction

   function automatic logic [CW-1:0] image();
      logic [CW-1:0] v;
      for (int i = 0; i < NR; i++) v[i*DW +: DW] = store_val(8'(i));
      return v;
   endfunction

   task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push(input int kind, input string tag, input logic [CW-1:0] exp);
      item_t it;
      it.kind = kind; it.tag = tag; it.exp = exp;
      sbq.push_back(it);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) begin
         @(posedge clk);
         #1;
      end
   endtask

   initial clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   // store model: request seen at a falling edge, data valid LAT falling edges later
   initial begin
      int         pend;
      logic [7:0] paddr;
      pend = 0; paddr = '0;
      rd_valid = 1'b0; rd_data = '0;
      forever begin
         @(negedge clk);
         rd_valid = 1'b0;
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               rd_valid = 1'b1;
               rd_data  = store_val(paddr);
            end
         end else if (rd_req === 1'b1) begin
            paddr = rd_addr[7:0];
            n_reads++;
            if (rd_addr[15:8] !== 8'hF8) n_badpre++;
            pend = LAT;
         end
      end
   end

   // monitor: compares queued expectations against the ports
   initial begin
      logic busy_d;
      busy_d = 1'b1;
      forever begin
         @(negedge clk);
         while (sbq.size() > 0) begin
            item_t it;
            logic [CW-1:0] act;
            it = sbq.pop_front();
            case (it.kind)
               K_CFG:   act = cfg_q;
               K_BUSY:  act = CW'(busy);
               default: act = CW'(ctrl_o);
            endcase
            chk(it.tag, act, it.exp);
         end
         if (busy_d && !busy && t_fall < 0) t_fall = cyc;
         if (seq_start) begin
            n_seq++;
            t_seq = cyc;
         end
         busy_d = busy;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [CW-1:0] exp;
      rst_n = 1'b0; pwr_good = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      push(K_BUSY, "R7 busy out of reset", 1);
      push(K_CFG,  "R1 reset state zero", '0);
      repeat (3) @(posedge clk);
      #1;
      push(K_BUSY, "R7 busy while power not good", 1);
      @(negedge clk);
      pwr_good = 1'b1;

      wr(8'd3, 8'hEE);
      while (busy) begin
         push(K_CFG, "R1 active config held during load", '0);
         @(posedge clk);
         #1;
      end
      exp = image();
      push(K_CFG, "R1 R2 all registers committed from store", exp);
      push(K_CFG, "R7 write during power-up load dropped", exp);
      push(K_CTRL, "R9 control reset readback", 0);
      chk("R2 one read per register", CW'(n_reads), CW'(NR));
      chk("R2 store address prefix", CW'(n_badpre), 0);

      wr(8'd2, 8'h55);
      push(K_CFG, "R4 staged write hidden", exp);
      wr(8'd5, 8'h66);
      push(K_CFG, "R4 second staged write hidden", exp);
      wr(A_CTRL, 8'h02);
      exp[2*DW +: DW] = 8'h55;
      exp[5*DW +: DW] = 8'h66;
      push(K_CFG, "R5 commit copies staged values", exp);
      push(K_CTRL, "R9 commit bit reads zero", 0);

      wr(A_CTRL, 8'h01);
      push(K_CTRL, "R9 transparent bit readback", 1);
      wr(8'd7, 8'h77);
      exp[7*DW +: DW] = 8'h77;
      push(K_CFG, "R3 transparent write immediate", exp);

      wr(A_CTRL, 8'h00);
      wr(8'd0, 8'h11);
      push(K_CFG, "R4 staged again after leaving transparent", exp);

      wr(A_DNLD, 8'h00);
      push(K_BUSY, "R6 download bit clear starts nothing", 0);
      wr(A_DNLD, 8'h01);
      push(K_BUSY, "R6 R8 busy on reload", 1);
      wr(8'd1, 8'h99);
      wr(A_CTRL, 8'h03);
      push(K_BUSY, "R8 busy held during reload", 1);
      wait_idle();
      exp = image();
      push(K_CFG, "R6 R8 reload restores stored values", exp);
      push(K_CTRL, "R8 control write during reload dropped", 0);
      chk("R6 reload reads every register", CW'(n_reads), CW'(2*NR));

      repeat (SD + 5) @(posedge clk);
      #1;
      chk("R10 one start pulse in total", CW'(n_seq), 1);
      chk("R10 start pulse delay", CW'(t_seq - t_fall), CW'(SD));

      @(negedge clk);
      pwr_good = 1'b0;
      @(posedge clk); #1;
      push(K_BUSY, "R7 busy after power loss", 1);
      @(negedge clk);
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule